// File: doc/BRIEF.md
# Edge-Triggered Phase-Frequency Comparator

This block compares a reference clock-like input against a feedback input and produces charge-pump style up and down drives for a downstream loop filter. Both inputs are asynchronous to the system clock. Each passes through a synchroniser and a rising-edge detector, so that only positive transitions matter. The comparison then runs in one of two modes, chosen by a mode pin.

The first mode is a three-state phase-frequency detector. The second mode is a set/reset phase detector, in which a reference edge sets the output and a feedback edge clears it. Alongside the drives, the block reports three things:
- a high-impedance indication, for when neither drive is active;
- an in-phase pulse, which is high while both drives are idle;
- a sticky lock flag, which rises after a programmable run of reference periods in which no drive pulse was longer than a programmable width.

Top module: `phase_freq_cmp`

## Requirements
- R1: Only rising transitions of `ref_i` and `fb_i` affect the outputs. The high time of either input does not change the drive waveform.
- R2: In phase-frequency mode (`mode_i` = 0) the state is one of neutral, up or down. A reference edge steps the state toward up, and up holds at up. A feedback edge steps the state toward down, and down holds at down.
- R3: When both inputs have the same period, the active drive stays on for exactly the edge-to-edge delay in system clocks. `up_o` is used when the reference leads and `dn_o` when it lags.
- R4: `hiz_o` and `in_phase_o` are 1 exactly when neither `up_o` nor `dn_o` is 1. In phase-frequency mode this happens in the neutral state.
- R5: With feedback edges only, `dn_o` stays asserted.
- R6: Reference and feedback edges detected in the same system clock cycle cancel, and the drives do not change.
- R7: In set/reset mode (`mode_i` = 1) a reference edge sets an internal flop and a feedback edge clears it. `up_o` equals the flop and `dn_o` equals its inverse.
- R8: In set/reset mode the fraction of time `up_o` is high equals the reference-to-feedback delay divided by the period. It is 50% when the delay is half a period.
- R9: A change of `mode_i` returns the detector to neutral (phase-frequency mode) or cleared (set/reset mode) on the next clock edge. The same change clears the lock flag and its progress.
- R10: `lock_o` rises on a reference edge that closes the `LOCK_PERIODS`-th consecutive reference period in which no continuous drive pulse lasted more than `MAX_PULSE` clocks. Once set, it stays set until reset or a mode change.
- R11: While `rst_i` is high, both drives are 0, `hiz_o` and `in_phase_o` are 1, and `lock_o` is 0.
- R12: An input rising edge that is set up before clock edge k changes the drives just after clock edge k+2, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| mode_i | input | 1 | 0 = phase-frequency, 1 = set/reset |
| ref_i | input | 1 | Asynchronous reference input |
| fb_i | input | 1 | Asynchronous feedback input |
| up_o | output | 1 | Up drive |
| dn_o | output | 1 | Down drive |
| hiz_o | output | 1 | Neither drive active |
| in_phase_o | output | 1 | High while both drives are idle |
| lock_o | output | 1 | Sticky lock indication |

## Verification
The drives are decoded directly from the registered detector state. A corrupted state therefore appears on `up_o`, `dn_o` and `hiz_o` in the very cycle after it is written, and it persists until the next detected edge moves it. A wrong step in the three-state sequence is visible at the third clock after the offending input edge. A wrong pulse-width or period count shows up later: `lock_o` rises one reference period too early or too late, or not at all, and because the flag is sticky the error then stays visible until reset.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

    typedef enum logic [1:0] {
        PFD_NEUTRAL = 2'd0,
        PFD_UP      = 2'd1,
        PFD_DOWN    = 2'd2
    } pfd_state_e;

    typedef enum logic {
        MODE_PFD = 1'b0,
        MODE_SR  = 1'b1
    } cmp_mode_e;

    typedef struct packed {
        pfd_state_e pfd;
        logic       sr;
        cmp_mode_e  mode;
    } det_regs_t;

    localparam int unsigned N_CH  = 2;
    localparam int unsigned CH_REF = 0;
    localparam int unsigned CH_FB  = 1;

endpackage

// File: rtl/pfc_edge_sync.sv
module pfc_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic async_i,
    output logic rise_o
);

    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              prev;
    } es_regs_t;

    es_regs_t es_d, es_q;

    always_comb begin
        es_d      = es_q;
        es_d.sync = {es_q.sync[STAGES-2:0], async_i};
        es_d.prev = es_q.sync[STAGES-1];
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            es_q <= '0;
        end else begin
            es_q <= es_d;
        end
    end

    assign rise_o = es_q.sync[STAGES-1] & ~es_q.prev;

    // R1: a rising edge is reported for one clock only, whatever the high time
    a_r1_single_cycle_rise: assert property (@(posedge clk_i) disable iff (rst_i)
        rise_o |=> !rise_o);

endmodule

// File: rtl/pfc_detector.sv
module pfc_detector
    import pfc_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic mode_i,
    input  logic ref_rise_i,
    input  logic fb_rise_i,
    output logic up_o,
    output logic dn_o,
    output logic mode_chg_o
);

    det_regs_t det_d, det_q;
    logic      one_edge;

    always_comb begin
        det_d      = det_q;
        det_d.mode = cmp_mode_e'(mode_i);
        mode_chg_o = (cmp_mode_e'(mode_i) != det_q.mode);
        one_edge   = ref_rise_i ^ fb_rise_i;

        if (mode_chg_o) begin
            det_d.pfd = PFD_NEUTRAL;
            det_d.sr  = 1'b0;
        end else if (one_edge) begin
            if (det_q.mode == MODE_PFD) begin
                unique case (det_q.pfd)
                    PFD_NEUTRAL: det_d.pfd = ref_rise_i ? PFD_UP : PFD_DOWN;
                    PFD_UP:      det_d.pfd = ref_rise_i ? PFD_UP : PFD_NEUTRAL;
                    PFD_DOWN:    det_d.pfd = ref_rise_i ? PFD_NEUTRAL : PFD_DOWN;
                    default:     det_d.pfd = PFD_NEUTRAL;
                endcase
            end else begin
                det_d.sr = ref_rise_i;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            det_q <= '{pfd: PFD_NEUTRAL, sr: 1'b0, mode: MODE_PFD};
        end else begin
            det_q <= det_d;
        end
    end

    assign up_o = (det_q.mode == MODE_PFD) ? (det_q.pfd == PFD_UP)   : det_q.sr;
    assign dn_o = (det_q.mode == MODE_PFD) ? (det_q.pfd == PFD_DOWN) : ~det_q.sr;

    // R2: a lone reference edge never leaves the down drive on
    a_r2_ref_never_down: assert property (@(posedge clk_i) disable iff (rst_i)
        (ref_rise_i && !fb_rise_i && !mode_chg_o && det_q.mode == MODE_PFD) |=> !dn_o);

    // R5: a lone feedback edge never leaves the up drive on
    a_r5_fb_never_up: assert property (@(posedge clk_i) disable iff (rst_i)
        (fb_rise_i && !ref_rise_i && !mode_chg_o && det_q.mode == MODE_PFD) |=> !up_o);

    // R6: coincident edges leave the drives untouched
    a_r6_cancel: assert property (@(posedge clk_i) disable iff (rst_i)
        (ref_rise_i && fb_rise_i && !mode_chg_o) |=> ($stable(up_o) && $stable(dn_o)));

    // R7: in set/reset mode a reference edge sets the output
    a_r7_sr_set: assert property (@(posedge clk_i) disable iff (rst_i)
        (ref_rise_i && !fb_rise_i && !mode_chg_o && det_q.mode == MODE_SR) |=> (up_o && !dn_o));

    // R9: a mode change leaves the up drive off
    a_r9_mode_clear: assert property (@(posedge clk_i) disable iff (rst_i)
        mode_chg_o |=> !up_o);

    // R4: the two drives are never on together
    a_r4_exclusive: assert property (@(posedge clk_i) disable iff (rst_i)
        !(up_o && dn_o));

endmodule

// File: rtl/pfc_lock_mon.sv
module pfc_lock_mon #(
    parameter int unsigned LOCK_PERIODS = 4,
    parameter int unsigned MAX_PULSE    = 8
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic clear_i,
    input  logic ref_rise_i,
    input  logic drive_i,
    output logic lock_o
);

    localparam int unsigned PW_W  = $clog2(MAX_PULSE + 1);
    localparam int unsigned CNT_W = $clog2(LOCK_PERIODS + 1);

    typedef struct packed {
        logic [PW_W-1:0]  width;
        logic             bad;
        logic [CNT_W-1:0] good;
        logic             lock;
    } lm_regs_t;

    lm_regs_t lm_d, lm_q;
    logic     exceed;
    logic     period_bad;

    always_comb begin
        lm_d       = lm_q;
        exceed     = drive_i && (lm_q.width >= PW_W'(MAX_PULSE));
        period_bad = lm_q.bad | exceed;

        if (!drive_i) begin
            lm_d.width = '0;
        end else if (!exceed) begin
            lm_d.width = lm_q.width + PW_W'(1);
        end

        if (clear_i) begin
            lm_d = '0;
        end else if (ref_rise_i) begin
            lm_d.bad = 1'b0;
            if (period_bad) begin
                lm_d.good = '0;
            end else if (int'(lm_q.good) < int'(LOCK_PERIODS)) begin
                lm_d.good = lm_q.good + CNT_W'(1);
            end
            lm_d.lock = lm_q.lock |
                        (!period_bad && (int'(lm_q.good) + 1 >= int'(LOCK_PERIODS)));
        end else begin
            lm_d.bad = period_bad;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            lm_q <= '0;
        end else begin
            lm_q <= lm_d;
        end
    end

    assign lock_o = lm_q.lock;

    // R10: the lock flag is sticky
    a_r10_lock_sticky: assert property (@(posedge clk_i) disable iff (rst_i)
        (lock_o && !clear_i) |=> lock_o);

    // R10: the lock flag can only rise on a reference edge
    a_r10_lock_on_ref: assert property (@(posedge clk_i) disable iff (rst_i)
        (!lock_o && !ref_rise_i) |=> !lock_o);

endmodule

// File: rtl/phase_freq_cmp.sv
module phase_freq_cmp
    import pfc_pkg::*;
#(
    parameter int unsigned SYNC_STAGES  = 2,
    parameter int unsigned LOCK_PERIODS = 4,
    parameter int unsigned MAX_PULSE    = 8
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic mode_i,
    input  logic ref_i,
    input  logic fb_i,
    output logic up_o,
    output logic dn_o,
    output logic hiz_o,
    output logic in_phase_o,
    output logic lock_o
);

    logic [N_CH-1:0] raw_in;
    logic [N_CH-1:0] rise;
    logic            mode_chg;
    logic            up_w;
    logic            dn_w;

    assign raw_in[CH_REF] = ref_i;
    assign raw_in[CH_FB]  = fb_i;

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_sync
        pfc_edge_sync #(
            .STAGES (SYNC_STAGES)
        ) u_sync (
            .clk_i   (clk_i),
            .rst_i   (rst_i),
            .async_i (raw_in[ch]),
            .rise_o  (rise[ch])
        );
    end

    pfc_detector u_det (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .mode_i     (mode_i),
        .ref_rise_i (rise[CH_REF]),
        .fb_rise_i  (rise[CH_FB]),
        .up_o       (up_w),
        .dn_o       (dn_w),
        .mode_chg_o (mode_chg)
    );

    pfc_lock_mon #(
        .LOCK_PERIODS (LOCK_PERIODS),
        .MAX_PULSE    (MAX_PULSE)
    ) u_lock (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .clear_i    (mode_chg),
        .ref_rise_i (rise[CH_REF]),
        .drive_i    (up_w | dn_w),
        .lock_o     (lock_o)
    );

    assign up_o       = up_w;
    assign dn_o       = dn_w;
    assign hiz_o      = ~(up_w | dn_w);
    assign in_phase_o = ~(up_w | dn_w);

endmodule

// File: tb/phase_freq_cmp_tb_top.sv
module phase_freq_cmp_tb_top;

    logic clk = 1'b0;
    logic rst_i, mode_i, ref_i, fb_i;
    logic up_o, dn_o, hiz_o, in_phase_o, lock_o;

    int cyc = 0;
    int n_checks = 0;
    int n_fail = 0;
    int win_from = 0;
    int win_to = 0;
    int up_cnt = 0;
    int dn_cnt = 0;

    typedef struct {
        int    due;
        logic  up;
        logic  dn;
        int    lock;
        string tag;
    } exp_t;

    exp_t sb_q[$];

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    phase_freq_cmp dut_i (
        .clk_i      (clk),
        .rst_i      (rst_i),
        .mode_i     (mode_i),
        .ref_i      (ref_i),
        .fb_i       (fb_i),
        .up_o       (up_o),
        .dn_o       (dn_o),
        .hiz_o      (hiz_o),
        .in_phase_o (in_phase_o),
        .lock_o     (lock_o)
    );

    // monitor: pops expectations when their cycle comes up
    always @(negedge clk) begin
        if (cyc > win_from && cyc <= win_to) begin
            if (up_o) up_cnt++;
            if (dn_o) dn_cnt++;
        end
        if (sb_q.size() > 0 && sb_q[0].due == cyc) begin
            exp_t e;
            logic idle;
            e = sb_q.pop_front();
            idle = ~(e.up | e.dn);
            n_checks++;
            if (up_o !== e.up || dn_o !== e.dn || hiz_o !== idle ||
                in_phase_o !== idle || (e.lock >= 0 && lock_o !== e.lock[0])) begin
                n_fail++;
                $display("FAIL %s: actual up=%b dn=%b hiz=%b inph=%b lock=%b expected up=%b dn=%b hiz=%b inph=%b lock=%0d",
                         e.tag, up_o, dn_o, hiz_o, in_phase_o, lock_o,
                         e.up, e.dn, idle, idle, e.lock);
            end
        end
    end

    task automatic expect_at(int delay, logic u, logic d, int l, string tag);
        exp_t e;
        e.due = cyc + delay;
        e.up = u;
        e.dn = d;
        e.lock = l;
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic check_cnt(int act, int exp, string tag);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // driver: raises the selected inputs, holds them hi clocks, step lasts gap clocks
    task automatic step(bit r, bit f, int hi, int gap, logic eu, logic ed, int el, string tag);
        if (r) ref_i = 1'b1;
        if (f) fb_i = 1'b1;
        expect_at(3, eu, ed, el, tag);
        repeat (hi) @(negedge clk);
        ref_i = 1'b0;
        fb_i = 1'b0;
        repeat (gap - hi) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_i = 1'b1;
        expect_at(2, 1'b0, 1'b0, 0, "R11 reset state");
        repeat (3) @(negedge clk);
        rst_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_mode(logic m, logic eu, logic ed, string tag);
        mode_i = m;
        expect_at(1, eu, ed, 0, tag);
        repeat (3) @(negedge clk);
    endtask

    task automatic open_window(int len);
        win_from = cyc;
        win_to = cyc + len;
        up_cnt = 0;
        dn_cnt = 0;
    endtask

    initial begin
        rst_i = 1'b1;
        mode_i = 1'b0;
        ref_i = 1'b0;
        fb_i = 1'b0;
        @(negedge clk);
        do_reset();

        // three-state behaviour (R2, R4, R5, R6)
        step(1, 0, 1, 8, 1, 0, -1, "R2 ref edge to up");
        step(1, 0, 5, 8, 1, 0, -1, "R2 up holds on ref");
        step(0, 1, 3, 8, 0, 0, -1, "R4 fb edge back to neutral");
        step(0, 1, 1, 8, 0, 1, -1, "R2 fb edge to down");
        step(0, 1, 6, 8, 0, 1, -1, "R5 feedback only keeps down");
        step(0, 1, 2, 8, 0, 1, -1, "R5 feedback only keeps down again");
        step(1, 1, 2, 8, 0, 1, -1, "R6 coincident edges in down");
        step(1, 0, 2, 8, 0, 0, -1, "R2 ref edge from down to neutral");
        step(1, 1, 4, 8, 0, 0, -1, "R6 coincident edges in neutral");

        // latency (R12)
        ref_i = 1'b1;
        expect_at(2, 1'b0, 1'b0, -1, "R12 no change before third edge");
        expect_at(3, 1'b1, 1'b0, -1, "R12 change after third edge");
        repeat (2) @(negedge clk);
        ref_i = 1'b0;
        repeat (6) @(negedge clk);
        step(0, 1, 2, 8, 0, 0, -1, "R4 back to neutral");

        // reference leads by 5 of 16 clocks, short ref high time (R3, R1)
        open_window(64);
        for (int i = 0; i < 4; i++) begin
            step(1, 0, 1, 5, 1, 0, -1, "R3 lead up on");
            step(0, 1, 1, 11, 0, 0, -1, "R3 lead up off");
        end
        check_cnt(up_cnt, 20, "R3 up time equals lead");
        check_cnt(dn_cnt, 0, "R3 no down while leading");

        // same lead, long high times (R1)
        open_window(64);
        for (int i = 0; i < 4; i++) begin
            step(1, 0, 4, 5, 1, 0, -1, "R1 lead up on, long high");
            step(0, 1, 9, 11, 0, 0, -1, "R1 lead up off, long high");
        end
        check_cnt(up_cnt, 20, "R1 duty cycle has no effect");

        // reference lags by 6 of 16 clocks (R3)
        open_window(64);
        for (int i = 0; i < 4; i++) begin
            step(0, 1, 2, 6, 0, 1, -1, "R3 lag down on");
            step(1, 0, 2, 10, 0, 0, -1, "R3 lag down off");
        end
        check_cnt(dn_cnt, 24, "R3 down time equals lag");
        check_cnt(up_cnt, 0, "R3 no up while lagging");

        // lock after aligned periods (R10)
        do_reset();
        step(1, 1, 2, 8, 0, 0, 0, "R10 aligned period 1");
        step(1, 1, 2, 8, 0, 0, 0, "R10 aligned period 2");
        step(1, 1, 2, 8, 0, 0, 0, "R10 aligned period 3");
        step(1, 1, 2, 8, 0, 0, 1, "R10 lock after 4 periods");
        step(1, 0, 2, 20, 1, 0, 1, "R10 lock sticky with long up");
        step(0, 1, 2, 8, 0, 0, 1, "R10 lock still set");

        // long pulse restarts the count (R10)
        do_reset();
        step(1, 0, 2, 16, 1, 0, 0, "R10 long up pulse");
        step(0, 1, 2, 8, 0, 0, 0, "R10 long pulse ended");
        step(1, 1, 2, 8, 0, 0, 0, "R10 bad period restarts count");
        step(1, 1, 2, 8, 0, 0, 0, "R10 good period 1");
        step(1, 1, 2, 8, 0, 0, 0, "R10 good period 2");
        step(1, 1, 2, 8, 0, 0, 0, "R10 good period 3 no lock");
        step(1, 1, 2, 8, 0, 0, 1, "R10 good period 4 locks");

        // mode change clears state and lock (R9)
        step(1, 0, 2, 8, 1, 0, 1, "R2 up before mode change");
        set_mode(1'b1, 1'b0, 1'b1, "R9 switch to set/reset clears");

        // set/reset mode (R7, R6)
        step(1, 0, 1, 8, 1, 0, 0, "R7 ref sets");
        step(1, 0, 3, 8, 1, 0, 0, "R7 stays set");
        step(0, 1, 2, 8, 0, 1, 0, "R7 fb clears");
        step(1, 1, 2, 8, 0, 1, 0, "R6 coincident in cleared");
        step(1, 0, 2, 8, 1, 0, 0, "R7 ref sets again");
        step(1, 1, 2, 8, 1, 0, 0, "R6 coincident in set");
        step(0, 1, 2, 8, 0, 1, 0, "R7 fb clears again");

        // half-period delay gives 50% (R8)
        open_window(64);
        for (int i = 0; i < 4; i++) begin
            step(1, 0, (i % 2 == 0) ? 1 : 6, 8, 1, 0, 0, "R8 half period set");
            step(0, 1, (i % 2 == 0) ? 6 : 1, 8, 0, 1, 0, "R8 half period clear");
        end
        check_cnt(up_cnt, 32, "R8 50 percent at half period");

        // quarter-period delay gives 25% (R8)
        open_window(64);
        for (int i = 0; i < 4; i++) begin
            step(1, 0, 1, 4, 1, 0, 0, "R8 quarter period set");
            step(0, 1, 1, 12, 0, 1, 0, "R8 quarter period clear");
        end
        check_cnt(up_cnt, 16, "R8 25 percent at quarter period");

        // back to phase-frequency from a set flop (R9)
        step(1, 0, 2, 8, 1, 0, 0, "R7 set before mode change");
        set_mode(1'b0, 1'b0, 1'b0, "R9 switch to phase-frequency neutral");
        step(1, 0, 2, 8, 1, 0, 0, "R2 ref to up after mode change");

        while (sb_q.size() > 0) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule